// File: doc/BRIEF.md
# Multi-Level Page Table Walker

This block turns a virtual page address into a real page address. It walks a tree of 8-byte table entries held in memory, from two to five levels deep. The tree holds up to three region levels, then a segment level, then a page level. The walk starts from one of three address-space descriptors, and a two-bit type field in that descriptor sets how many levels the walk covers. A lookup request enters on a valid/ready channel. The result leaves on a second valid/ready channel and carries one of two things:
- a real address with read, write and execute permissions, or
- a fault with a fault code and a translation-exception word.

Table reads go out on a memory port. The request side of that port is valid/ready. The response side is valid only, and the walker waits for it before it moves to the next level.

The walker serves one lookup at a time. It drops `req_ready` from the cycle a request is accepted until the result has been taken. The result stays on the output while `rsp_ready` is low, which is how a consumer applies back-pressure. Translation enable, 64-bit addressing mode and the three descriptor registers are plain control inputs. They are sampled when a request is accepted. There is no caching of earlier results.

Top module: `xlat_walker`

## Requirements
- R1: `req_ready` is high only while no lookup is in progress. A request is accepted on a cycle where both `req_valid` and `req_ready` are high. `rsp_valid`, together with every result field, holds unchanged until a cycle where `rsp_ready` is high, and no new request is accepted before then.
- R2: With `xlat_en` low, the result is the virtual address with its low 12 bits cleared, with permissions 3'b111 (bit 0 read, bit 1 write, bit 2 execute), no fault, and no memory read.
- R3: With `wide_mode` low, the virtual address is cut to its low 31 bits before any other step. The cut applies to the result address, the table offsets and the exception word.
- R4: `req_mode` selects the space: 0 primary (`cr_prim`), 1 secondary (`cr_sec`), 2 home (`cr_home`), 3 treated as primary. The space that is used sets bits [1:0] of every exception word to 1 for primary, 2 for secondary and 3 for home.
- R5: Descriptor bits [1:0] give the start level: 3 region-first, 2 region-second, 1 region-third, 0 segment. If the address has any bit set that the type cannot reach, the result is a specification fault (code 0) and no memory is read. Type 2 covers bits 63..53, type 1 covers bits 63..42, and type 0 covers bits 63..31.
- R6: If descriptor bit 5 (real space) is set, no memory is read and the result address equals the page-aligned virtual address, with the same permissions a valid writable page would get.
- R7: A descriptor of type t causes t+2 table reads, fewer if the walk faults. Each read address is the table origin plus a byte offset. The offset is (v>>50)&0x3ff8 at region-first, (v>>39)&0x3ff8 at region-second, (v>>28)&0x3ff8 at region-third, (v>>17)&0x3ff8 at segment, and (v>>9)&0x7f8 at page level. Origins are bits [63:12] of the descriptor or region entry, and bits [63:11] of a segment entry.
- R8: A region or segment entry with bit 5 set ends the walk with a segment fault (code 1).
- R9: A region entry must carry in bits [1:0] the type of the table it points to (region-first entry 2, region-second entry 1, region-third entry 0). Any other value ends the walk with a specification fault (code 0).
- R10: A page entry with bit 10 set gives a page fault (code 2). Otherwise the real address is the page entry with its low 12 bits cleared.
- R11: A page entry with bit 9 set clears write permission. A write (`req_acc` = 1) to such a page gives a protection fault (code 3), and bit 2 of the exception word is set.
- R12: In secondary mode (`req_mode` = 1), an instruction fetch (`req_acc` = 2) walks the primary space and gets permissions 3'b100. A data access (`req_acc` 0 or 1, with 3 treated as read) walks the secondary space with execute cleared.
- R13: `mem_req_valid` and `mem_req_addr` hold stable until `mem_req_ready` is high. The next read is issued only after `mem_rsp_valid` has delivered the entry for the previous read.
- R14: On a fault, `rsp_fault` is 1, `rsp_raddr` and `rsp_perm` are 0, and `rsp_tec` is the page-aligned virtual address ORed with the space bits. Without a fault, `rsp_tec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 64 | Virtual address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 fetch |
| req_mode | input | 2 | Address-space mode |
| xlat_en | input | 1 | Translation enable |
| wide_mode | input | 1 | 64-bit addressing; low selects 31-bit |
| cr_prim | input | 64 | Primary space descriptor |
| cr_sec | input | 64 | Secondary space descriptor |
| cr_home | input | 64 | Home space descriptor |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Entry data |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_raddr | output | 64 | Real page address |
| rsp_perm | output | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| rsp_fault | output | 1 | Lookup ended in a fault |
| rsp_code | output | 2 | Fault code: 0 specification, 1 segment, 2 page, 3 protection |
| rsp_tec | output | 64 | Translation-exception word |

## Verification
The checker assumes that memory returns exactly one `mem_rsp_valid` pulse for each accepted read, and only while that read is outstanding. It also assumes that the descriptor and mode inputs do not change under a walk in a way that matters, since they are sampled at acceptance. The bench memory model keeps to these assumptions in three ways:
- It answers each handshake once, after a random delay of zero to two cycles.
- It holds `mem_req_ready` low while an answer is pending.
- It changes the control inputs only between lookups.

Every table the walker may touch is built beforehand at 4 KiB or 2 KiB aligned origins. Because of that alignment, entry addresses are always 8-byte aligned.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VA_W      = 64;
  localparam int PG_SH     = 12;
  localparam int PT_SH     = 11;
  localparam int D_REAL_B  = 5;
  localparam int E_INV_B   = 5;
  localparam int P_RO_B    = 9;
  localparam int P_INV_B   = 10;

  typedef enum logic [2:0] {
    LV_PAGE = 3'd0,
    LV_SEG  = 3'd1,
    LV_R3   = 3'd2,
    LV_R2   = 3'd3,
    LV_R1   = 3'd4
  } lvl_e;

  typedef enum logic [1:0] {
    FC_SPEC = 2'd0,
    FC_SEG  = 2'd1,
    FC_PAGE = 2'd2,
    FC_PROT = 2'd3
  } fcode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_MREQ  = 2'd1,
    S_MWAIT = 2'd2,
    S_RESP  = 2'd3
  } wst_e;

  // byte offset of the entry inside the table at a given level
  function automatic logic [VA_W-1:0] tbl_offset(input lvl_e l, input logic [VA_W-1:0] v);
    logic [VA_W-1:0] o;
    case (l)
      LV_PAGE: o = {53'd0, v[19:12], 3'd0};
      LV_SEG:  o = {50'd0, v[30:20], 3'd0};
      LV_R3:   o = {50'd0, v[41:31], 3'd0};
      LV_R2:   o = {50'd0, v[52:42], 3'd0};
      default: o = {50'd0, v[63:53], 3'd0};
    endcase
    return o;
  endfunction
endpackage

// File: rtl/xw_req_decode.sv
module xw_req_decode
  import xw_pkg::*;
(
  input  logic [VA_W-1:0] vaddr,
  input  logic [1:0]      acc,
  input  logic [1:0]      mode,
  input  logic            wide,
  input  logic [VA_W-1:0] cr_p,
  input  logic [VA_W-1:0] cr_s,
  input  logic [VA_W-1:0] cr_h,
  output logic [VA_W-1:0] vpage,
  output logic [1:0]      sp_code,
  output logic [VA_W-1:0] desc,
  output logic            is_fetch,
  output logic            is_write,
  output logic            sec_mode,
  output logic            range_bad,
  output lvl_e            start_lvl
);
  logic [VA_W-1:0] v_cut;
  logic            unused_low;

  assign v_cut      = wide ? vaddr : {33'd0, vaddr[30:0]};
  assign vpage      = {v_cut[VA_W-1:PG_SH], {PG_SH{1'b0}}};
  assign unused_low = ^v_cut[PG_SH-1:0];

  assign is_fetch = (acc == 2'd2);
  assign is_write = (acc == 2'd1);
  assign sec_mode = (mode == 2'd1);

  always_comb begin
    if (sec_mode)          sp_code = is_fetch ? 2'd1 : 2'd2;
    else if (mode == 2'd2) sp_code = 2'd3;
    else                   sp_code = 2'd1;
    case (sp_code)
      2'd2:    desc = cr_s;
      2'd3:    desc = cr_h;
      default: desc = cr_p;
    endcase
  end

  always_comb begin
    case (desc[1:0])
      2'd2:    range_bad = |vpage[63:53];
      2'd1:    range_bad = |vpage[63:42];
      2'd0:    range_bad = |vpage[63:31];
      default: range_bad = 1'b0;
    endcase
  end

  assign start_lvl = lvl_e'({1'b0, desc[1:0]} + 3'd1);
endmodule

// File: rtl/xw_entry_eval.sv
module xw_entry_eval
  import xw_pkg::*;
(
  input  lvl_e            lvl,
  input  logic [VA_W-1:0] entry,
  output logic            inval,
  output logic            type_bad,
  output logic            ro,
  output logic [VA_W-1:0] nxt_origin,
  output lvl_e            nxt_lvl,
  output logic [VA_W-1:0] frame
);
  logic unused_bits;
  assign unused_bits = ^{entry[8:6], entry[4:2]};

  assign inval    = (lvl == LV_PAGE) ? entry[P_INV_B] : entry[E_INV_B];
  assign type_bad = (lvl >= LV_R3) && ({1'b0, entry[1:0]} != (lvl - 3'd2));
  assign ro       = entry[P_RO_B];
  assign frame    = {entry[VA_W-1:PG_SH], {PG_SH{1'b0}}};
  assign nxt_origin = (lvl == LV_SEG) ? {entry[VA_W-1:PT_SH], {PT_SH{1'b0}}} : frame;
  assign nxt_lvl  = lvl_e'(lvl - 3'd1);
endmodule

// File: rtl/xw_perm.sv
module xw_perm (
  input  logic       sec_mode,
  input  logic       is_fetch,
  input  logic       is_write,
  input  logic       ro,
  output logic [2:0] perm,
  output logic       prot
);
  assign perm = (sec_mode && is_fetch) ? 3'b100 : {!sec_mode, !ro, 1'b1};
  assign prot = is_write && ro;
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_vaddr,
  input  logic [1:0]      req_acc,
  input  logic [1:0]      req_mode,
  input  logic            xlat_en,
  input  logic            wide_mode,
  input  logic [63:0]     cr_prim,
  input  logic [63:0]     cr_sec,
  input  logic [63:0]     cr_home,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [63:0]     mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [63:0]     mem_rsp_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [63:0]     rsp_raddr,
  output logic [2:0]      rsp_perm,
  output logic            rsp_fault,
  output logic [1:0]      rsp_code,
  output logic [63:0]     rsp_tec
);
  wst_e            st;
  logic [VA_W-1:0] vpage_q, origin_q;
  logic [1:0]      sp_q;
  logic            fetch_q, write_q, sec_q;
  lvl_e            lvl_q;

  logic [VA_W-1:0] d_vpage, d_desc;
  logic [1:0]      d_sp;
  logic            d_fetch, d_write, d_sec, d_range_bad;
  lvl_e            d_start;
  logic            unused_desc;

  logic            e_inval, e_type_bad, e_ro;
  logic [VA_W-1:0] e_nxt_org, e_frame;
  lvl_e            e_nxt_lvl;

  logic [2:0]      real_perm, pg_perm;
  logic            real_prot, pg_prot;
  logic [VA_W-1:0] tec_base;

  xw_req_decode u_dec (
    .vaddr(req_vaddr), .acc(req_acc), .mode(req_mode), .wide(wide_mode),
    .cr_p(cr_prim), .cr_s(cr_sec), .cr_h(cr_home),
    .vpage(d_vpage), .sp_code(d_sp), .desc(d_desc),
    .is_fetch(d_fetch), .is_write(d_write), .sec_mode(d_sec),
    .range_bad(d_range_bad), .start_lvl(d_start)
  );

  xw_entry_eval u_ent (
    .lvl(lvl_q), .entry(mem_rsp_data),
    .inval(e_inval), .type_bad(e_type_bad), .ro(e_ro),
    .nxt_origin(e_nxt_org), .nxt_lvl(e_nxt_lvl), .frame(e_frame)
  );

  xw_perm u_perm_real (
    .sec_mode(d_sec), .is_fetch(d_fetch), .is_write(d_write), .ro(1'b0),
    .perm(real_perm), .prot(real_prot)
  );

  xw_perm u_perm_page (
    .sec_mode(sec_q), .is_fetch(fetch_q), .is_write(write_q), .ro(e_ro),
    .perm(pg_perm), .prot(pg_prot)
  );

  assign unused_desc  = ^{d_desc[11:6], d_desc[4:2], real_prot};
  assign tec_base     = vpage_q | {{(VA_W-2){1'b0}}, sp_q};

  assign req_ready     = (st == S_IDLE);
  assign rsp_valid     = (st == S_RESP);
  assign mem_req_valid = (st == S_MREQ);
  assign mem_req_addr  = origin_q + tbl_offset(lvl_q, vpage_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      vpage_q   <= '0;
      origin_q  <= '0;
      sp_q      <= 2'd0;
      fetch_q   <= 1'b0;
      write_q   <= 1'b0;
      sec_q     <= 1'b0;
      lvl_q     <= LV_PAGE;
      rsp_raddr <= '0;
      rsp_perm  <= 3'd0;
      rsp_fault <= 1'b0;
      rsp_code  <= FC_SPEC;
      rsp_tec   <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          vpage_q   <= d_vpage;
          sp_q      <= d_sp;
          fetch_q   <= d_fetch;
          write_q   <= d_write;
          sec_q     <= d_sec;
          rsp_raddr <= '0;
          rsp_perm  <= 3'd0;
          rsp_fault <= 1'b0;
          rsp_code  <= FC_SPEC;
          rsp_tec   <= '0;
          if (!xlat_en) begin
            rsp_raddr <= d_vpage;
            rsp_perm  <= 3'b111;
            st        <= S_RESP;
          end else if (d_range_bad) begin
            rsp_fault <= 1'b1;
            rsp_code  <= FC_SPEC;
            rsp_tec   <= d_vpage | {{(VA_W-2){1'b0}}, d_sp};
            st        <= S_RESP;
          end else if (d_desc[D_REAL_B]) begin
            rsp_raddr <= d_vpage;
            rsp_perm  <= real_perm;
            st        <= S_RESP;
          end else begin
            origin_q  <= {d_desc[VA_W-1:PG_SH], {PG_SH{1'b0}}};
            lvl_q     <= d_start;
            st        <= S_MREQ;
          end
        end
        S_MREQ: if (mem_req_ready) st <= S_MWAIT;
        S_MWAIT: if (mem_rsp_valid) begin
          if (lvl_q == LV_PAGE) begin
            st <= S_RESP;
            if (e_inval) begin
              rsp_fault <= 1'b1;
              rsp_code  <= FC_PAGE;
              rsp_tec   <= tec_base;
            end else if (pg_prot) begin
              rsp_fault <= 1'b1;
              rsp_code  <= FC_PROT;
              rsp_tec   <= tec_base | 64'd4;
            end else begin
              rsp_raddr <= e_frame;
              rsp_perm  <= pg_perm;
            end
          end else if (e_inval) begin
            rsp_fault <= 1'b1;
            rsp_code  <= FC_SEG;
            rsp_tec   <= tec_base;
            st        <= S_RESP;
          end else if (e_type_bad) begin
            rsp_fault <= 1'b1;
            rsp_code  <= FC_SPEC;
            rsp_tec   <= tec_base;
            st        <= S_RESP;
          end else begin
            origin_q <= e_nxt_org;
            lvl_q    <= e_nxt_lvl;
            st       <= S_MREQ;
          end
        end
        default: if (rsp_ready) st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xw_walker_chk.sv
module xw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [63:0] mem_req_addr,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [63:0] rsp_raddr,
  input logic [2:0]  rsp_perm,
  input logic        rsp_fault,
  input logic [1:0]  rsp_code,
  input logic [63:0] rsp_tec
);
  p_busy_no_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_rsp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_raddr) && $stable(rsp_perm)
      && $stable(rsp_fault) && $stable(rsp_code) && $stable(rsp_tec));

  p_mreq_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_mreq_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !rsp_valid && !req_ready);

  p_mreq_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[2:0] == 3'd0);

  p_page_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_raddr[11:0] == 12'd0);

  p_fault_clear_r14: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_perm == 3'd0 && rsp_raddr == 64'd0);

  p_tec_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_tec[1:0] != 2'd0);

  p_prot_mark_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_tec[2] == (rsp_code == 2'd3));

  p_ok_tec_zero_r14: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_tec == 64'd0);
endmodule

bind xlat_walker xw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_raddr(rsp_raddr), .rsp_perm(rsp_perm),
  .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_tec(rsp_tec)
);

// File: tb/xlat_walker_tb_top.sv
module xlat_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, xlat_en = 1, wide_mode = 1;
  logic [63:0] req_vaddr = 0, cr_prim = 0, cr_sec = 0, cr_home = 0;
  logic [1:0]  req_acc = 0, req_mode = 0;
  logic        mem_req_ready = 0, mem_rsp_valid = 0, rsp_ready = 0;
  logic [63:0] mem_rsp_data = 0;
  logic        req_ready, mem_req_valid, rsp_valid, rsp_fault;
  logic [63:0] mem_req_addr, rsp_raddr, rsp_tec;
  logic [2:0]  rsp_perm;
  logic [1:0]  rsp_code;

  xlat_walker dut_i (.*);

  int checks = 0, errors = 0;
  int nreads = 0;
  logic [63:0] asum = 0;
  logic [63:0] mem [logic [63:0]];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0BAD_0000_0000_0020;
  endfunction

  function automatic logic [63:0] boff(input int l, input logic [63:0] v);
    case (l)
      0: return (v >> 9)  & 64'h7f8;
      1: return (v >> 17) & 64'h3ff8;
      2: return (v >> 28) & 64'h3ff8;
      3: return (v >> 39) & 64'h3ff8;
      default: return (v >> 50) & 64'h3ff8;
    endcase
  endfunction

  // memory responder: one answer per handshake, 0..2 cycles later
  initial begin
    bit hs, pend;
    int dly;
    logic [63:0] a, aq;
    pend = 0; dly = 0; aq = 0;
    forever begin
      @(posedge clk);
      hs = mem_req_valid && mem_req_ready;
      a  = mem_req_addr;
      @(negedge clk);
      mem_rsp_valid = 0;
      if (hs) begin pend = 1; dly = $urandom % 3; aq = a; nreads++; asum += a; end
      if (pend) begin
        if (dly == 0) begin mem_rsp_valid = 1; mem_rsp_data = rd(aq); pend = 0; end
        else dly--;
      end
      mem_req_ready = !pend && ($urandom % 4 != 0);
    end
  end

  // builds a chain of tables for page v; returns descriptor
  function automatic logic [63:0] build(input logic [63:0] v, input int t, input int inj,
                                        input int badl, input bit ro, input bit realsp);
    logic [63:0] org, nxt, ent, d;
    mem.delete();
    org = (64'(t + 1) << 24) | (64'($urandom & 16'hfff) << 12);
    d   = org | 64'(t) | (realsp ? 64'h20 : 64'h0);
    for (int l = t + 1; l >= 1; l--) begin
      if (l == 1) nxt = (64'd6 << 24) | (64'($urandom & 16'hfff) << 11);
      else        nxt = (64'(l - 1) << 24) | (64'($urandom & 16'hfff) << 12);
      ent = nxt | ((l >= 2) ? 64'(l - 2) : 64'h0);
      if (inj == 1 && l == badl) ent |= 64'h20;
      if (inj == 2 && l == badl && l >= 2) ent ^= 64'h1;
      mem[org + boff(l, v)] = ent;
      org = nxt;
    end
    ent = (64'($urandom) << 20) | (ro ? 64'h200 : 64'h0) | ((inj == 3) ? 64'h400 : 64'h0);
    mem[org + boff(0, v)] = ent;
    return d;
  endfunction

  // reference result from the requirements
  task automatic model(input logic [63:0] va, input logic [1:0] acc, input logic [1:0] mode,
                       input bit xen, input bit wide,
                       output bit f, output logic [1:0] code, output logic [63:0] ra,
                       output logic [2:0] perm, output logic [63:0] tec,
                       output int nr, output logic [63:0] sum);
    logic [63:0] v, d, org, e, a;
    logic [1:0] sp, t;
    bit ro, fetch, wr, sec, stop;
    v = wide ? va : (va & 64'h7fff_ffff);
    v = v & ~64'hfff;
    f = 0; code = 0; ra = 0; perm = 0; tec = 0; nr = 0; sum = 0; ro = 0;
    if (!xen) begin ra = v; perm = 3'b111; return; end
    fetch = (acc == 2); wr = (acc == 1); sec = (mode == 1);
    sp = sec ? (fetch ? 2'd1 : 2'd2) : (mode == 2 ? 2'd3 : 2'd1);
    d = (sp == 1) ? cr_prim : (sp == 2) ? cr_sec : cr_home;
    t = d[1:0];
    if ((t == 2 && v[63:53] != 0) || (t == 1 && v[63:42] != 0) || (t == 0 && v[63:31] != 0)) begin
      f = 1; code = 0; tec = v | 64'(sp); return;
    end
    if (d[5]) ra = v;
    else begin
      org = d & ~64'hfff;
      stop = 0;
      for (int l = int'(t) + 1; l >= 1 && !stop; l--) begin
        a = org + boff(l, v); e = rd(a); nr++; sum += a;
        if (e[5]) begin f = 1; code = 1; stop = 1; end
        else if (l >= 2 && int'(e[1:0]) != l - 2) begin f = 1; code = 0; stop = 1; end
        else org = (l == 1) ? (e & ~64'h7ff) : (e & ~64'hfff);
      end
      if (f) begin tec = v | 64'(sp); return; end
      a = org + boff(0, v); e = rd(a); nr++; sum += a;
      if (e[10]) begin f = 1; code = 2; tec = v | 64'(sp); return; end
      ro = e[9]; ra = e & ~64'hfff;
    end
    if (wr && ro) begin f = 1; code = 3; ra = 0; tec = v | 64'(sp) | 64'd4; return; end
    perm = (sec && fetch) ? 3'b100 : {!sec, !ro, 1'b1};
  endtask

  task automatic run_case(input string tag, input logic [63:0] va, input int t, input int inj,
                          input int badl, input bit ro, input bit realsp, input logic [1:0] mode,
                          input logic [1:0] acc, input bit wide, input bit xen);
    bit ef; logic [1:0] ec; logic [63:0] er, et, esum, vv, d, r0; logic [2:0] ep;
    int en, h, wd;
    vv = wide ? va : (va & 64'h7fff_ffff);
    d = build(vv & ~64'hfff, t, inj, badl, ro, realsp);
    @(negedge clk);
    cr_prim = {$urandom, $urandom} | 64'h20; cr_sec = cr_prim; cr_home = cr_prim;
    if (mode == 1 && acc != 2) cr_sec = d;
    else if (mode == 2) cr_home = d;
    else cr_prim = d;
    req_vaddr = va; req_acc = acc; req_mode = mode; wide_mode = wide; xlat_en = xen;
    model(va, acc, mode, xen, wide, ef, ec, er, ep, et, en, esum);
    nreads = 0; asum = 0;
    req_valid = 1;
    do @(posedge clk); while (!req_ready);
    @(negedge clk);
    req_valid = 0;
    wd = 0;
    while (!rsp_valid && wd < 200) begin @(negedge clk); wd++; end
    chk(rsp_valid, tag, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_fault == ef, tag, "fault", 64'(rsp_fault), 64'(ef));
    if (ef) chk(rsp_code == ec, tag, "code", 64'(rsp_code), 64'(ec));
    chk(rsp_raddr == er, tag, "raddr", rsp_raddr, er);
    chk(rsp_perm == ep, tag, "perm", 64'(rsp_perm), 64'(ep));
    chk(rsp_tec == et, tag, "tec", rsp_tec, et);
    chk(nreads == en, tag, "R7 read count", 64'(nreads), 64'(en));
    chk(asum == esum, tag, "R7 read address sum", asum, esum);
    h = $urandom % 3; r0 = rsp_raddr;
    for (int i = 0; i < h; i++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_raddr == r0, "R1", "hold under back-pressure", rsp_raddr, r0);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(req_ready && !rsp_valid, "R1", "idle after take", 64'(req_ready), 64'd1);
  endtask

  // R13: address stable while not accepted
  logic [63:0] last_a; bit last_wait = 0;
  always @(negedge clk) begin
    if (rst_n && last_wait)
      chk(mem_req_valid && mem_req_addr == last_a, "R13", "mem request hold", mem_req_addr, last_a);
    last_wait = mem_req_valid && !mem_req_ready;
    last_a = mem_req_addr;
  end

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !mem_req_valid, "R1", "reset outputs idle", 64'(rsp_valid), 64'd0);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1", "ready after reset", 64'(req_ready), 64'd1);
    // directed corner cases
    run_case("R2", 64'h1234_5678_9abc_def0, 3, 0, 0, 0, 0, 0, 1, 1, 0);
    run_case("R3", 64'hffff_ffff_ffff_f123, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_case("R3", 64'hffff_0000_7654_3000, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    run_case("R4", 64'h0000_0000_0123_4000, 0, 3, 0, 0, 0, 2, 0, 1, 1);
    run_case("R4", 64'h0000_0000_0123_4000, 0, 3, 0, 0, 0, 3, 0, 1, 1);
    run_case("R5", 64'h0020_0000_0000_0000, 2, 0, 0, 0, 0, 0, 0, 1, 1);
    run_case("R5", 64'h0000_0400_0000_0000, 1, 0, 0, 0, 0, 0, 0, 1, 1);
    run_case("R5", 64'h0000_0000_8000_0000, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    run_case("R6", 64'h0000_0000_0055_5000, 0, 0, 0, 1, 1, 0, 1, 1, 1);
    run_case("R7", 64'hfedc_ba98_7654_3000, 3, 0, 0, 0, 0, 0, 0, 1, 1);
    run_case("R8", 64'h0000_0012_3456_7000, 2, 1, 1, 0, 0, 0, 0, 1, 1);
    run_case("R8", 64'h0000_0012_3456_7000, 3, 1, 4, 0, 0, 0, 0, 1, 1);
    run_case("R9", 64'h0000_0012_3456_7000, 3, 2, 3, 0, 0, 0, 0, 1, 1);
    run_case("R10", 64'h0000_0000_0aaa_b000, 0, 3, 0, 0, 0, 0, 0, 1, 1);
    run_case("R11", 64'h0000_0000_0aaa_b000, 1, 0, 0, 1, 0, 0, 1, 1, 1);
    run_case("R11", 64'h0000_0000_0aaa_b000, 1, 0, 0, 1, 0, 0, 0, 1, 1);
    run_case("R12", 64'h0000_0000_0bbb_c000, 1, 0, 0, 0, 0, 1, 2, 1, 1);
    run_case("R12", 64'h0000_0000_0bbb_c000, 1, 0, 0, 1, 0, 1, 1, 1, 1);
    run_case("R14", 64'h0000_0000_0ccc_d000, 2, 3, 0, 0, 0, 1, 0, 1, 1);
    // constrained random
    for (int n = 0; n < 300; n++) begin
      logic [63:0] va; int t, inj, bl; bit rsp_real;
      t = $urandom % 4;
      va = {$urandom, $urandom};
      if ($urandom % 8 != 0) begin
        if (t == 2) va[63:53] = 0;
        if (t == 1) va[63:42] = 0;
        if (t == 0) va[63:31] = 0;
      end
      inj = ($urandom % 3 == 0) ? 1 + $urandom % 3 : 0;
      bl = 1 + $urandom % (t + 1);
      rsp_real = ($urandom % 10 == 0);
      run_case("R7", va, t, inj, bl, 1'($urandom), rsp_real, 2'($urandom),
               2'($urandom % 3), ($urandom % 6 != 0), ($urandom % 10 != 0));
    end
    finish_run();
  end
endmodule